// File: doc/BRIEF.md
# Three-move staircase arc stepper

This block turns a clockwise quarter-circle arc in the first quadrant into two streams of unit step pulses, one for the X axis and one for the Y axis. Each iteration moves the tool point by one of three moves. The first adds one unit to X. The second takes one unit from Y. The third does both at once.

A diagonal move can stand in for a pair of single-axis moves. This shortens the step sequence and keeps the traced points closer to the true circle than a path that alternates single-axis moves.

The caller sets the arc start point, end point and radius, then pulses a start strobe. Each iteration tick then advances the point by one move. Ticks are paced by an external feed-rate source. The block reports the current coordinates and a busy flag, and it gives a one-cycle done pulse when the end point is reached.

The move is picked by comparing the circle error x² + y² − R² at the three candidate points. This error is kept incrementally with additions only. Squares are formed once, when the arc is loaded.

Top module: `arc_stair_interp`

## Requirements
- R1: After reset, busy, done, both step outputs and both coordinates are 0.
- R2: A start strobe while idle loads the start point onto the coordinate outputs at the next clock edge. Busy rises at that edge unless the start point already equals the end point. A start strobe while busy is ignored: coordinates and busy are unchanged.
- R3: Every tick while busy performs exactly one move. Its step pulses and new coordinates appear at the first clock edge after the tick, and each step pulse lasts one cycle. A tick while idle has no effect on steps or coordinates.
- R4: The moves are +1 on X (stepX alone), −1 on Y (stepY alone), or both together. A diagonal move raises stepX and stepY in the same cycle.
- R5: Among the allowed moves, the one whose next point has the smallest |x² + y² − R²| is taken. Ties go to the diagonal first, then to the +X move.
- R6: No move overshoots the end point. Once X equals the end X, only −Y moves follow. Once Y equals the end Y, only +X moves follow.
- R7: Done is a one-cycle pulse, raised in the same cycle the coordinates first equal the end point, and busy falls in that cycle. The total X pulses equal endX − startX and the total Y pulses equal startY − endY.
- R8: A start strobe with the start point equal to the end point gives a done pulse at the next edge, no step pulse, and busy stays low.
- R9: For the arc from (0,10) to (10,0) with radius 10, the block finishes in 14 iterations, fewer than the 20 single-axis steps the arc spans. Every visited point lies within one half unit of the circle radially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | Load arc and begin |
| tick | input | 1 | Iteration request |
| startX | input | COORD_W | Arc start X |
| startY | input | COORD_W | Arc start Y |
| endX | input | COORD_W | Arc end X (not below startX) |
| endY | input | COORD_W | Arc end Y (not above startY) |
| radius | input | COORD_W | Arc radius |
| stepX | output | 1 | +X step pulse |
| stepY | output | 1 | −Y step pulse |
| curX | output | COORD_W | Current X |
| curY | output | COORD_W | Current Y |
| busy | output | 1 | Arc in progress |
| done | output | 1 | End point reached, one cycle |

## Verification
The bench builds the block with the default 8-bit coordinates. It sweeps every radius from 1 to 8 together with every end point inside the quarter-circle box. This covers degenerate arcs, arcs that run only along X, and arcs that end early and clip to the −Y-only or +X-only regions. Extra arcs start off-axis for radii up to 9. A software model that squares the coordinates directly predicts each move. The reference radius-10 arc is checked for its iteration count and its half-unit radial bound.

// File: rtl/circ_pkg.sv
package circ_pkg;
  // Strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic load;
    logic advX;
    logic advY;
  } dpCmd_t;
endpackage

// File: rtl/circ_datapath.sv
module circ_datapath
  import circ_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCmd_t             cmd,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  input  logic [COORD_W-1:0] endX,
  input  logic [COORD_W-1:0] endY,
  input  logic [COORD_W-1:0] radius,
  output logic [COORD_W-1:0] curX,
  output logic [COORD_W-1:0] curY,
  output logic               stepX,
  output logic               stepY,
  output logic               loadAtEnd,
  output logic               pickX,
  output logic               pickY,
  output logic               moveFinal
);
  localparam int SQ_W  = 2 * COORD_W;
  localparam int ERR_W = SQ_W + 3;
  localparam int PAD   = ERR_W - SQ_W;
  localparam int LIFT  = ERR_W - COORD_W - 1;

  typedef logic signed [ERR_W-1:0] err_t;
  localparam err_t ONE = err_t'(1);

  function automatic logic [ERR_W-1:0] mag(input err_t v);
    return v[ERR_W-1] ? ERR_W'(-v) : ERR_W'(v);
  endfunction

  // Squares are formed only when an arc is loaded
  logic [SQ_W-1:0] sqX, sqY, sqR;
  assign sqX = {{COORD_W{1'b0}}, startX} * {{COORD_W{1'b0}}, startX};
  assign sqY = {{COORD_W{1'b0}}, startY} * {{COORD_W{1'b0}}, startY};
  assign sqR = {{COORD_W{1'b0}}, radius} * {{COORD_W{1'b0}}, radius};

  err_t errAcc, errInit, twoX, twoY, errX, errY, errD;
  logic [ERR_W-1:0] magX, magY, magD;
  logic [COORD_W-1:0] endXq, endYq, nextX, nextY;
  logic xAtEnd, yAtEnd;

  assign errInit = $signed({{PAD{1'b0}}, sqX}) + $signed({{PAD{1'b0}}, sqY})
                 - $signed({{PAD{1'b0}}, sqR});

  // Incremental error of the three candidate points
  assign twoX = $signed({{LIFT{1'b0}}, curX, 1'b0});
  assign twoY = $signed({{LIFT{1'b0}}, curY, 1'b0});
  assign errX = errAcc + twoX + ONE;
  assign errY = errAcc - twoY + ONE;
  assign errD = errX - twoY + ONE;
  assign magX = mag(errX);
  assign magY = mag(errY);
  assign magD = mag(errD);

  assign xAtEnd    = curX >= endXq;
  assign yAtEnd    = curY <= endYq;
  assign loadAtEnd = (startX >= endX) && (startY <= endY);

  always_comb begin
    pickX = 1'b0;
    pickY = 1'b0;
    if (xAtEnd && yAtEnd) begin
      pickX = 1'b0;
    end else if (xAtEnd) begin
      pickY = 1'b1;
    end else if (yAtEnd) begin
      pickX = 1'b1;
    end else if (magD <= magX && magD <= magY) begin
      pickX = 1'b1;
      pickY = 1'b1;
    end else if (magX <= magY) begin
      pickX = 1'b1;
    end else begin
      pickY = 1'b1;
    end
  end

  assign nextX     = pickX ? curX + 1'b1 : curX;
  assign nextY     = pickY ? curY - 1'b1 : curY;
  assign moveFinal = (nextX >= endXq) && (nextY <= endYq);

  always_ff @(posedge clk) begin
    if (rst) begin
      curX   <= '0;
      curY   <= '0;
      endXq  <= '0;
      endYq  <= '0;
      errAcc <= '0;
      stepX  <= 1'b0;
      stepY  <= 1'b0;
    end else begin
      stepX <= cmd.advX;
      stepY <= cmd.advY;
      if (cmd.load) begin
        curX   <= startX;
        curY   <= startY;
        endXq  <= endX;
        endYq  <= endY;
        errAcc <= errInit;
      end else begin
        if (cmd.advX) curX <= curX + 1'b1;
        if (cmd.advY) curY <= curY - 1'b1;
        case ({cmd.advX, cmd.advY})
          2'b11:   errAcc <= errD;
          2'b10:   errAcc <= errX;
          2'b01:   errAcc <= errY;
          default: errAcc <= errAcc;
        endcase
      end
    end
  end

  // R4: every X pulse moves the point by exactly one unit
  p_unit_step_x_r4: assert property (@(posedge clk) disable iff (rst)
    stepX |-> curX == $past(curX) + 1'b1);
  // R4: every Y pulse moves the point down by exactly one unit
  p_unit_step_y_r4: assert property (@(posedge clk) disable iff (rst)
    stepY |-> curY == $past(curY) - 1'b1);
  // R6: the point never leaves the box bounded by the end point
  p_in_box_r6: assert property (@(posedge clk) disable iff (rst)
    curX <= endXq && curY >= endYq);
endmodule

// File: rtl/circ_control.sv
module circ_control
  import circ_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   startPulse,
  input  logic   tick,
  input  logic   loadAtEnd,
  input  logic   pickX,
  input  logic   pickY,
  input  logic   moveFinal,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   done
);
  logic advance;

  assign advance  = busy & tick;
  assign cmd.load = startPulse & ~busy;
  assign cmd.advX = advance & pickX;
  assign cmd.advY = advance & pickY;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= (cmd.load & loadAtEnd) | (advance & moveFinal);
      if (cmd.load)                busy <= ~loadAtEnd;
      else if (advance & moveFinal) busy <= 1'b0;
    end
  end

  // R7: done only appears once the arc has been retired
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R3: a tick while busy always finds a legal move
  p_tick_moves_r3: assert property (@(posedge clk) disable iff (rst)
    busy && tick |-> (pickX || pickY));
endmodule

// File: rtl/arc_stair_interp.sv
module arc_stair_interp
  import circ_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startPulse,
  input  logic               tick,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  input  logic [COORD_W-1:0] endX,
  input  logic [COORD_W-1:0] endY,
  input  logic [COORD_W-1:0] radius,
  output logic               stepX,
  output logic               stepY,
  output logic [COORD_W-1:0] curX,
  output logic [COORD_W-1:0] curY,
  output logic               busy,
  output logic               done
);
  dpCmd_t cmd;
  logic   loadAtEnd, pickX, pickY, moveFinal;

  circ_control u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startPulse(startPulse),
    .tick      (tick),
    .loadAtEnd (loadAtEnd),
    .pickX     (pickX),
    .pickY     (pickY),
    .moveFinal (moveFinal),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done)
  );

  circ_datapath #(.COORD_W(COORD_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .startX   (startX),
    .startY   (startY),
    .endX     (endX),
    .endY     (endY),
    .radius   (radius),
    .curX     (curX),
    .curY     (curY),
    .stepX    (stepX),
    .stepY    (stepY),
    .loadAtEnd(loadAtEnd),
    .pickX    (pickX),
    .pickY    (pickY),
    .moveFinal(moveFinal)
  );

  // R3: step pulses only follow a tick taken while busy
  p_step_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (stepX || stepY) |-> $past(tick && busy));
  // R7: done coincides with the end point (end inputs held during an arc)
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (curX == endX && curY == endY));
  // R2: a start strobe during an arc does not reload the point
  p_busy_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    busy && startPulse && !tick |=> (curX == $past(curX) && curY == $past(curY) && busy));
endmodule

// File: tb/sim_arc_stair_interp.sv
module sim_arc_stair_interp;
  localparam int CW = 8;

  logic clk = 1'b0, rst = 1'b1, startPulse = 1'b0, tick = 1'b0;
  logic [CW-1:0] startX = '0, startY = '0, endX = '0, endY = '0, radius = '0;
  logic stepX, stepY, busy, done;
  logic [CW-1:0] curX, curY;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  arc_stair_interp #(.COORD_W(CW)) u0 (
    .clk(clk), .rst(rst), .startPulse(startPulse), .tick(tick),
    .startX(startX), .startY(startY), .endX(endX), .endY(endY), .radius(radius),
    .stepX(stepX), .stepY(stepY), .curX(curX), .curY(curY), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int errOf(input int x, input int y, input int r);
    return x * x + y * y - r * r;
  endfunction

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Move code: bit0 = +X, bit1 = -Y
  function automatic int pickMove(input int x, input int y, input int ex, input int ey, input int r);
    int aX, aY, aD;
    if (x >= ex && y <= ey) return 0;
    if (x >= ex) return 2;
    if (y <= ey) return 1;
    aX = absI(errOf(x + 1, y, r));
    aY = absI(errOf(x, y - 1, r));
    aD = absI(errOf(x + 1, y - 1, r));
    if (aD <= aX && aD <= aY) return 3;
    if (aX <= aY) return 1;
    return 2;
  endfunction

  task automatic runArc(input int sx, input int sy, input int ex, input int ey, input int r,
                        input bit poke, input bit gap, input bit refCase, output int iters);
    int mx, my, px, py, mv;
    mx = sx; my = sy; px = 0; py = 0; iters = 0;
    startX = CW'(sx); startY = CW'(sy); endX = CW'(ex); endY = CW'(ey); radius = CW'(r);
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    chk(int'(curX) == sx, "R2 load curX", int'(curX), sx);
    chk(int'(curY) == sy, "R2 load curY", int'(curY), sy);
    if (sx == ex && sy == ey) begin
      chk(done == 1'b1, "R8 done", int'(done), 1);
      chk(busy == 1'b0 && stepX == 1'b0 && stepY == 1'b0, "R8 idle", int'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 done width", int'(done), 0);
      return;
    end
    chk(busy == 1'b1 && done == 1'b0, "R2 busy", int'(busy), 1);
    while (!(mx == ex && my == ey) && iters < 200) begin
      mv = pickMove(mx, my, ex, ey, r);
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      mx += mv & 1;
      my -= (mv >> 1) & 1;
      px += mv & 1;
      py += (mv >> 1) & 1;
      iters++;
      chk(stepX == mv[0], "R4 R5 stepX", int'(stepX), mv & 1);
      chk(stepY == mv[1], "R4 R5 stepY", int'(stepY), (mv >> 1) & 1);
      chk(int'(curX) == mx && int'(curY) == my, "R5 R6 point",
          int'(curX) * 1000 + int'(curY), mx * 1000 + my);
      if (mx == ex && my == ey)
        chk(done == 1'b1 && busy == 1'b0, "R7 done at end", int'(done), 1);
      else
        chk(busy == 1'b1 && done == 1'b0, "R3 still busy", int'(busy), 1);
      if (refCase)
        chk(4 * (mx * mx + my * my) >= (2 * r - 1) * (2 * r - 1) &&
            4 * (mx * mx + my * my) <= (2 * r + 1) * (2 * r + 1),
            "R9 radial", 4 * (mx * mx + my * my), 4 * r * r);
      if (poke && iters == 1 && busy) begin
        startPulse = 1'b1;
        @(negedge clk); startPulse = 1'b0;
        chk(int'(curX) == mx && int'(curY) == my && busy == 1'b1, "R2 start ignored",
            int'(curX) * 1000 + int'(curY), mx * 1000 + my);
      end
      if (gap) begin
        @(negedge clk);
        chk(stepX == 1'b0 && stepY == 1'b0, "R3 pulse width", int'(stepX) + int'(stepY), 0);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done width", int'(done), 0);
    chk(px == ex - sx, "R7 X pulse total", px, ex - sx);
    chk(py == sy - ey, "R7 Y pulse total", py, sy - ey);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk(stepX == 1'b0 && stepY == 1'b0, "R3 idle tick steps", int'(stepX) + int'(stepY), 0);
    chk(int'(curX) == ex && int'(curY) == ey, "R3 idle tick point",
        int'(curX) * 1000 + int'(curY), ex * 1000 + ey);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual %0d cycles expected fewer", 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int it;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'(busy) + int'(done), 0);
    chk(stepX == 1'b0 && stepY == 1'b0, "R1 reset steps", int'(stepX) + int'(stepY), 0);
    chk(curX == '0 && curY == '0, "R1 reset point", int'(curX) + int'(curY), 0);
    rst = 1'b0;

    // R9 reference arc
    runArc(0, 10, 10, 0, 10, 1'b0, 1'b0, 1'b1, it);
    chk(it == 14, "R9 iterations", it, 14);
    chk(it < 20, "R9 fewer than single-axis", it, 20);

    // R8 degenerate arc
    runArc(5, 5, 5, 5, 7, 1'b0, 1'b0, 1'b0, it);

    // R2 start strobe during an arc
    runArc(0, 8, 8, 0, 8, 1'b1, 1'b0, 1'b0, it);

    // Sweep of radii and end points (R5, R6, R7)
    for (int r = 1; r <= 8; r++)
      for (int ex = 0; ex <= r; ex++)
        for (int ey = 0; ey <= r; ey++)
          runArc(0, r, ex, ey, r, 1'b0, ((ex + ey) % 3) == 0, 1'b0, it);

    // Off-axis starting points
    for (int r = 4; r <= 9; r++)
      runArc(2, r - 1, r, 1, r, 1'b0, 1'b1, 1'b0, it);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule